// File: doc/BRIEF.md
# Chunked NAND Page Layout Remapper

This block sits between the chunk transfer engine of a NAND controller and a page buffer. A page arrives from the flash as a byte stream cut into chunks, and each chunk carries its data bytes, then its spare bytes, then its ECC bytes. For every byte the block works out where it belongs in a logical page image and emits a write toward the buffer. Software then reads one contiguous page and does not see the chunk interleave.

Two modes are supported. The normal mode places every data byte of the page first and the spare bytes of all chunks after them, in chunk order, and it drops ECC bytes. The OOB mode places the data area the same way and then, for each chunk in order, that chunk's spare bytes followed directly by its ECC bytes. Two geometries are available, both for a 4096-byte page: two chunks of 2048 data bytes, or four chunks of 1024 data bytes. Each chunk has 32 spare bytes and 30 ECC bytes in both geometries.

The input stream and the write port both use a valid/ready handshake. The block holds no buffer. A byte that will be written is accepted only in a cycle where the write port is ready, so back-pressure from the buffer passes straight to the source. A byte that is dropped is accepted at once. Mode and geometry are sampled on a one-cycle start pulse, which also restarts the page.

Top module: `nand_page_remap`

## Requirements
- R1: After reset, `wr_valid`, `done` and `geom_err` are low, `in_ready` is high, and no write is made until a start pulse with a supported geometry.
- R2: Geometry code 0 selects two chunks of 2048 data bytes and code 1 selects four chunks of 1024 data bytes. Data byte `o` of chunk `c` is written at address `c*chunk_data_bytes + o` in both modes.
- R3: In normal mode (`oob_mode`=0), spare byte `o` of chunk `c` is written at `4096 + 32*c + o`. The 30 ECC bytes of every chunk are accepted with `in_ready` high and produce no write.
- R4: In OOB mode (`oob_mode`=1), spare byte `o` of chunk `c` is written at `4096 + 62*c + o`, and ECC byte `o` of chunk `c` is written at `4096 + 62*c + 32 + o`.
- R5: `done` is high for exactly one cycle, the cycle after the last ECC byte of the last chunk is accepted. From then until the next start pulse, bytes are accepted and no writes are made.
- R6: While a byte is due to be written, `wr_valid` follows `in_valid`, `wr_byte` equals `in_byte`, and `in_ready` equals `wr_ready`. When `wr_ready` is low the byte is not consumed and the write address holds.
- R7: A start pulse with geometry code 2 or 3 raises `geom_err` from the next cycle until the next start pulse. During that time no writes are made and input bytes are accepted and discarded.
- R8: In the cycle where `start` is high, `in_ready` and `wr_valid` are low and no byte is consumed. The start pulse abandons any page in progress and samples `oob_mode` and `geom_sel` for the new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start of page pulse |
| oob_mode | input | 1 | 0 = normal layout, 1 = OOB layout (sampled on start) |
| geom_sel | input | 2 | Geometry code (sampled on start) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_byte | input | 8 | Raw byte from the flash stream |
| wr_valid | output | 1 | Write request toward the page buffer |
| wr_ready | input | 1 | Page buffer accepts the write |
| wr_addr | output | 13 | Byte address in the logical page image |
| wr_byte | output | 8 | Byte to write |
| done | output | 1 | One-cycle pulse after the final byte of the page |
| geom_err | output | 1 | Unsupported geometry code seen on the last start |

## Verification
The start pulse can arrive in the same cycle as a valid input byte, and the write handshake can stall in the same cycle that the page ends or that the field boundaries move. The bench drives `start` with `in_valid` held high, aborts pages in the middle, and toggles `in_valid` and `wr_ready` at random on every cycle. A behavioural model tracks a flat byte position within the page and predicts `in_ready`, `wr_valid`, `wr_addr`, `wr_byte`, `done` and `geom_err` on every clock. The model checks that a colliding byte is not consumed and that the next page starts at address 0.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  // Field currently being walked inside a chunk
  typedef enum logic [1:0] {
    FLD_DATA  = 2'd0,
    FLD_SPARE = 2'd1,
    FLD_ECC   = 2'd2
  } fld_e;

  // Geometry codes on geom_sel
  localparam logic [1:0] GEOM_WIDE   = 2'd0;  // large data chunks
  localparam logic [1:0] GEOM_NARROW = 2'd1;  // small data chunks

endpackage

// File: rtl/nrm_geom_decode.sv
module nrm_geom_decode #(
  parameter int PAGE_BYTES  = 4096,
  parameter int CHUNK_WIDE  = 2048,
  parameter int CHUNK_NARR  = 1024,
  parameter int LEN_W       = 12,
  parameter int CH_W        = 2
) (
  input  logic [1:0]       sel,
  output logic             ok,
  output logic [LEN_W-1:0] chunk_len,
  output logic [CH_W-1:0]  last_chunk
);
  import nrm_pkg::*;

  localparam int NCH_WIDE = PAGE_BYTES / CHUNK_WIDE;
  localparam int NCH_NARR = PAGE_BYTES / CHUNK_NARR;

  always_comb begin
    ok         = 1'b0;
    chunk_len  = '0;
    last_chunk = '0;
    unique case (sel)
      GEOM_WIDE: begin
        ok         = 1'b1;
        chunk_len  = LEN_W'(CHUNK_WIDE);
        last_chunk = CH_W'(NCH_WIDE - 1);
      end
      GEOM_NARROW: begin
        ok         = 1'b1;
        chunk_len  = LEN_W'(CHUNK_NARR);
        last_chunk = CH_W'(NCH_NARR - 1);
      end
      default: begin
        ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nrm_walker.sv
module nrm_walker #(
  parameter int LEN_W       = 12,
  parameter int CH_W        = 2,
  parameter int SPARE_BYTES = 32,
  parameter int ECC_BYTES   = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,     // start pulse with good geometry
  input  logic               abort,       // start pulse with bad geometry
  input  logic [LEN_W-1:0]   chunk_len,
  input  logic [CH_W-1:0]    last_chunk,
  input  logic               step,        // one byte consumed
  output logic               run,
  output nrm_pkg::fld_e      fld,
  output logic [CH_W-1:0]    chunk,
  output logic [LEN_W-2:0]   offset,
  output logic               done
);
  import nrm_pkg::*;

  logic [LEN_W-1:0] fld_len;
  logic             fld_last;
  logic             page_last;

  always_comb begin
    unique case (fld)
      FLD_DATA:  fld_len = chunk_len;
      FLD_SPARE: fld_len = LEN_W'(SPARE_BYTES);
      default:   fld_len = LEN_W'(ECC_BYTES);
    endcase
  end

  assign fld_last  = ({1'b0, offset} == (fld_len - LEN_W'(1)));
  assign page_last = (fld == FLD_ECC) && fld_last && (chunk == last_chunk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fld    <= FLD_DATA;
      chunk  <= '0;
      offset <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (restart || abort) begin
        run    <= restart;
        fld    <= FLD_DATA;
        chunk  <= '0;
        offset <= '0;
      end else if (run && step) begin
        if (!fld_last) begin
          offset <= offset + 1'b1;
        end else begin
          offset <= '0;
          unique case (fld)
            FLD_DATA:  fld <= FLD_SPARE;
            FLD_SPARE: fld <= FLD_ECC;
            default: begin
              fld <= FLD_DATA;
              if (page_last) begin
                run  <= 1'b0;
                done <= 1'b1;
                chunk <= '0;
              end else begin
                chunk <= chunk + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nrm_addr_gen.sv
module nrm_addr_gen #(
  parameter int PAGE_BYTES  = 4096,
  parameter int SPARE_BYTES = 32,
  parameter int ECC_BYTES   = 30,
  parameter int LEN_W       = 12,
  parameter int CH_W        = 2,
  parameter int ADDR_W      = 13
) (
  input  logic              oob,
  input  nrm_pkg::fld_e     fld,
  input  logic [CH_W-1:0]   chunk,
  input  logic [LEN_W-2:0]  offset,
  input  logic [LEN_W-1:0]  chunk_len,
  output logic              keep,
  output logic [ADDR_W-1:0] addr
);
  import nrm_pkg::*;

  localparam logic [ADDR_W-1:0] PAGE_A   = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] SPARE_A  = ADDR_W'(SPARE_BYTES);
  localparam logic [ADDR_W-1:0] OOB_STEP = ADDR_W'(SPARE_BYTES + ECC_BYTES);

  logic [ADDR_W-1:0] ch_a, off_a, len_a, stride;
  logic [ADDR_W-1:0] data_a, spare_a, ecc_a;

  assign ch_a   = ADDR_W'(chunk);
  assign off_a  = ADDR_W'(offset);
  assign len_a  = ADDR_W'(chunk_len);
  assign stride = oob ? OOB_STEP : SPARE_A;

  assign data_a  = ch_a * len_a + off_a;
  assign spare_a = PAGE_A + ch_a * stride + off_a;
  assign ecc_a   = PAGE_A + ch_a * OOB_STEP + SPARE_A + off_a;

  always_comb begin
    unique case (fld)
      FLD_DATA:  begin addr = data_a;  keep = 1'b1; end
      FLD_SPARE: begin addr = spare_a; keep = 1'b1; end
      default:   begin addr = ecc_a;   keep = oob;  end
    endcase
  end

endmodule

// File: rtl/nand_page_remap.sv
module nand_page_remap #(
  parameter int PAGE_BYTES  = 4096,
  parameter int CHUNK_WIDE  = 2048,
  parameter int CHUNK_NARR  = 1024,
  parameter int SPARE_BYTES = 32,
  parameter int ECC_BYTES   = 30,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = $clog2(PAGE_BYTES + (PAGE_BYTES / CHUNK_NARR) * (SPARE_BYTES + ECC_BYTES))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              oob_mode,
  input  logic [1:0]        geom_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              done,
  output logic              geom_err
);
  import nrm_pkg::*;

  localparam int LEN_W = $clog2(CHUNK_WIDE) + 1;
  localparam int CH_W  = $clog2(PAGE_BYTES / CHUNK_NARR);

  logic             g_ok;
  logic [LEN_W-1:0] g_len, len_q;
  logic [CH_W-1:0]  g_last, last_q;
  logic             oob_q;
  logic             run, keep, step;
  fld_e             fld;
  logic [CH_W-1:0]  chunk;
  logic [LEN_W-2:0] offset;

  nrm_geom_decode #(
    .PAGE_BYTES(PAGE_BYTES), .CHUNK_WIDE(CHUNK_WIDE), .CHUNK_NARR(CHUNK_NARR),
    .LEN_W(LEN_W), .CH_W(CH_W)
  ) geom_i (
    .sel(geom_sel), .ok(g_ok), .chunk_len(g_len), .last_chunk(g_last)
  );

  // Page parameters captured on the start pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oob_q    <= 1'b0;
      len_q    <= LEN_W'(CHUNK_WIDE);
      last_q   <= '0;
      geom_err <= 1'b0;
    end else if (start) begin
      oob_q    <= oob_mode;
      len_q    <= g_ok ? g_len : len_q;
      last_q   <= g_ok ? g_last : last_q;
      geom_err <= !g_ok;
    end
  end

  nrm_walker #(
    .LEN_W(LEN_W), .CH_W(CH_W), .SPARE_BYTES(SPARE_BYTES), .ECC_BYTES(ECC_BYTES)
  ) walk_i (
    .clk(clk), .rst_n(rst_n),
    .restart(start && g_ok), .abort(start && !g_ok),
    .chunk_len(len_q), .last_chunk(last_q), .step(step),
    .run(run), .fld(fld), .chunk(chunk), .offset(offset), .done(done)
  );

  nrm_addr_gen #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES), .ECC_BYTES(ECC_BYTES),
    .LEN_W(LEN_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) addr_i (
    .oob(oob_q), .fld(fld), .chunk(chunk), .offset(offset), .chunk_len(len_q),
    .keep(keep), .addr(wr_addr)
  );

  // Handshake: writes stall on wr_ready, dropped bytes are swallowed
  assign in_ready = !start && (!run || !keep || wr_ready);
  assign wr_valid = !start && run && keep && in_valid;
  assign wr_byte  = in_byte;
  assign step     = in_valid && in_ready;

endmodule

// File: rtl/nrm_checker.sv
module nrm_checker #(
  parameter int PAGE_BYTES  = 4096,
  parameter int CHUNK_NARR  = 1024,
  parameter int SPARE_BYTES = 32,
  parameter int ECC_BYTES   = 30,
  parameter int ADDR_W      = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              oob_mode,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              geom_err
);
  localparam int MAXCH = PAGE_BYTES / CHUNK_NARR;
  localparam logic [ADDR_W:0] NORM_END = (ADDR_W+1)'(PAGE_BYTES + MAXCH * SPARE_BYTES);

  logic mode_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)     mode_seen <= 1'b0;
    else if (start) mode_seen <= oob_mode;
  end

  // R1: nothing is written before a page is started
  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !wr_valid && !done);

  // R3: normal mode never writes past the spare area (ECC dropped)
  p_ecc_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !mode_seen |-> {1'b0, wr_addr} < NORM_END);

  // R5: done is a single-cycle pulse with no write beside it
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n) done |-> !wr_valid);

  // R6: stalled write back-pressures the input and holds its address
  p_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !in_ready);
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> start || !wr_valid || $stable(wr_addr));

  // R7: no writes while the geometry error is flagged
  p_no_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n) geom_err |-> !wr_valid);

  // R8: the start cycle consumes nothing
  p_start_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready && !wr_valid);

endmodule

bind nand_page_remap nrm_checker #(
  .PAGE_BYTES(PAGE_BYTES), .CHUNK_NARR(CHUNK_NARR), .SPARE_BYTES(SPARE_BYTES),
  .ECC_BYTES(ECC_BYTES), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .oob_mode(oob_mode),
  .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .done(done), .geom_err(geom_err)
);

// File: tb/nand_page_remap_tb.sv
module nand_page_remap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, oob_mode = 1'b0, in_valid = 1'b0, wr_ready = 1'b0;
  logic [1:0] geom_sel = 2'd0;
  logic [7:0] in_byte = 8'd0;
  logic in_ready, wr_valid, done, geom_err;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_byte;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_remap dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .oob_mode(oob_mode), .geom_sel(geom_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .done(done), .geom_err(geom_err)
  );

  // Behavioural model: flat byte position within the page
  bit m_run = 0, m_oob = 0, m_err = 0, m_done = 0;
  int m_pos = 0, m_len = 2048, m_nch = 2;

  function automatic int per_chunk(); return m_len + 62; endfunction

  // region: 0 data, 1 spare, 2 ecc
  function automatic int region();
    int r = m_pos % per_chunk();
    if (r < m_len) return 0;
    if (r < m_len + 32) return 1;
    return 2;
  endfunction

  function automatic int exp_addr();
    int c = m_pos / per_chunk();
    int r = m_pos % per_chunk();
    if (r < m_len) return c * m_len + r;
    if (r < m_len + 32) return 4096 + c * (m_oob ? 62 : 32) + (r - m_len);
    return 4096 + c * 62 + (r - m_len);
  endfunction

  function automatic bit exp_keep(); return m_run && (region() != 2 || m_oob); endfunction
  function automatic bit exp_in_ready(); return !start && (!m_run || !exp_keep() || wr_ready); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_err = 0; m_done = 0; m_pos = 0; m_oob = 0;
    end else begin
      m_done = 0;
      if (start) begin
        m_err = (geom_sel > 2'd1);
        m_run = !m_err;
        m_pos = 0;
        m_oob = oob_mode;
        if (!m_err) begin
          m_len = (geom_sel == 2'd0) ? 2048 : 1024;
          m_nch = 4096 / m_len;
        end
      end else if (m_run && in_valid && exp_in_ready()) begin
        m_pos++;
        if (m_pos == m_nch * per_chunk()) begin
          m_run = 0; m_done = 1; m_pos = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare everything on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      string tg;
      ev = exp_keep() && in_valid && !start;
      tg = start ? "R8" : m_err ? "R7" : (m_run && region() == 2 && !m_oob) ? "R3" : "R6";
      chk(wr_valid == ev, tg, "wr_valid", wr_valid, ev);
      chk(in_ready == exp_in_ready(), start ? "R8" : "R6", "in_ready", in_ready, exp_in_ready());
      if (ev && wr_valid) begin
        tg = region() == 0 ? "R2" : m_oob ? "R4" : "R3";
        chk(int'(wr_addr) == exp_addr(), tg, "wr_addr", wr_addr, exp_addr());
        chk(wr_byte == in_byte, "R6", "wr_byte", wr_byte, in_byte);
      end
      chk(done == m_done, "R5", "done", done, m_done);
      chk(geom_err == m_err, "R7", "geom_err", geom_err, m_err);
    end
  end

  task automatic do_page(input logic [1:0] g, input bit oob, input int max_cyc,
                         input int vpct, input int rpct);
    @(posedge clk); #1;
    start = 1; geom_sel = g; oob_mode = oob;
    in_valid = 1; in_byte = 8'($urandom); wr_ready = 1;   // R8: collide with a valid byte
    @(posedge clk); #1;
    start = 0;
    for (int i = 0; i < max_cyc; i++) begin
      in_valid = ($urandom % 100) < vpct;
      in_byte  = 8'($urandom);
      wr_ready = ($urandom % 100) < rpct;
      @(posedge clk); #1;
      if (!m_run) break;
    end
    // R5/R7: trailing bytes after the page must be swallowed without writes
    for (int i = 0; i < 16; i++) begin
      in_valid = 1; in_byte = 8'($urandom); wr_ready = 1;
      @(posedge clk); #1;
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    chk(wr_valid == 0, "R1", "wr_valid", wr_valid, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(geom_err == 0, "R1", "geom_err", geom_err, 0);

    do_page(2'd0, 1'b0, 20000, 100, 100);  // R2 R3 wide, normal, no stalls
    do_page(2'd1, 1'b0, 20000, 70, 60);    // R2 R3 narrow, normal, stalls
    do_page(2'd0, 1'b1, 20000, 60, 70);    // R4 wide, OOB
    do_page(2'd1, 1'b1, 20000, 80, 50);    // R4 narrow, OOB
    do_page(2'd2, 1'b0, 200, 90, 90);      // R7 bad geometry
    do_page(2'd3, 1'b1, 200, 90, 90);      // R7 bad geometry
    do_page(2'd1, 1'b1, 1500, 90, 80);     // R8 abandoned mid-page
    do_page(2'd0, 1'b0, 2100, 100, 100);   // R8 abandoned near spare boundary
    do_page(2'd1, 1'b0, 20000, 50, 90);    // R5 full page after abort

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule